// File: doc/BRIEF.md
# Stereo Transmit Sample FIFO

This block sits between a host write port and an audio transmit serializer. The host presents a left-channel word and then a right-channel word. The left word waits in a holding register. The right-word write commits the two words together as one entry of a small stereo FIFO. The serializer pulls one stereo pair per request. If it asks while the FIFO is empty, it receives a silent (all-zero) pair and a sticky underflow flag is raised.

Two interrupt outputs help the host keep the FIFO fed:

- **Fill-level interrupt.** Its threshold is selectable: at most half full, or completely empty.
- **Underflow interrupt.** It follows the sticky flag when its enable input is set.

Dropping the channel enable flushes the FIFO and its pointers. This lets software recover a stream that has lost pair alignment by toggling the enable.

Top module: `stereo_tx_fifo`

## Requirements
- R1: After reset the FIFO is empty: `full` is 0, `sample_left`/`sample_right` are 0, `uf_flag` and `uf_irq` are 0.
- R2: A pulse on `wr_right` stores one entry of {held left word, `wr_data`}. A `rd_req` pulse with the FIFO non-empty places the oldest entry on `sample_left`/`sample_right` in the cycle after the request edge. Entries leave in the order they were written.
- R3: The FIFO holds DEPTH (default 8) pairs. `full` is 1 exactly when DEPTH pairs are stored.
- R4: A right write while full is dropped: the stored contents and their order are unchanged.
- R5: A second `wr_left` before the `wr_right` replaces the held left word. Only the latest left word is committed.
- R6: With `lvl_sel`=0, `fill_irq` is 1 while the channel is enabled and the stored count is at most DEPTH/2.
- R7: With `lvl_sel`=1, `fill_irq` is 1 while the channel is enabled and the FIFO is empty.
- R8: A `rd_req` on an empty, enabled FIFO outputs a zero pair and sets `uf_flag`. The flag stays set until a `uf_clear` pulse. A new underflow in the same cycle as `uf_clear` keeps the flag set.
- R9: `uf_irq` equals `uf_flag` AND `uf_irq_en`.
- R10: While `chan_en` is 0, the FIFO is flushed and the held left word is cleared. `full` and `fill_irq` read 0, and writes and reads are ignored. After re-enable the FIFO starts empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 1 | Channel enable; low flushes the FIFO |
| wr_left | input | 1 | Left-word write strobe |
| wr_right | input | 1 | Right-word write strobe (commits the pair) |
| wr_data | input | SAMPLE_W | Write data for either strobe |
| lvl_sel | input | 1 | Fill interrupt threshold: 0 = half empty, 1 = empty |
| uf_irq_en | input | 1 | Underflow interrupt enable |
| uf_clear | input | 1 | Clears the sticky underflow flag |
| rd_req | input | 1 | Serializer pulls one pair |
| sample_left | output | SAMPLE_W | Left word of the last pulled pair |
| sample_right | output | SAMPLE_W | Right word of the last pulled pair |
| full | output | 1 | FIFO holds DEPTH pairs |
| fill_irq | output | 1 | Fill-level interrupt |
| uf_flag | output | 1 | Sticky underflow flag |
| uf_irq | output | 1 | Underflow interrupt |

## Verification
The bench sweeps every fill level from zero to DEPTH. At each level it checks `full` and both interrupt thresholds. An off-by-one compare would flip `fill_irq` at the half-way level, and a wrong full compare would lose or accept the ninth pair.

It then overfills, drains and reads past empty:

- A design that stored dropped writes would return a stale or foreign pair.
- A design that failed to zero on underflow would repeat the last sample.

The clear-versus-set collision, the replaced left word and the flush on disable are each driven on their own. A lost pending flag or unreset pointers would show up as wrong pairs or a non-empty FIFO after re-enable.

// File: rtl/stf_pkg.sv
// Package: shared types for the stereo transmit FIFO.
// Assumes nothing beyond IEEE 1800-2017.
package stf_pkg;

    // Threshold choice for the fill-level interrupt.
    typedef enum logic {
        LVL_HALF  = 1'b0,
        LVL_EMPTY = 1'b1
    } stf_lvl_e;

endpackage

// File: rtl/stf_pair_buffer.sv
// Pair buffer: circular store of stereo pairs with read/write pointers
// and an occupancy count. Assumes DEPTH is a power of two so pointers
// wrap naturally. Push while full and pop while empty are ignored here.
module stf_pair_buffer #(
    parameter int SAMPLE_W = 16,
    parameter int DEPTH    = 8,
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int CNT_W   = PTR_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                push,
    input  logic [SAMPLE_W-1:0] push_left,
    input  logic [SAMPLE_W-1:0] push_right,
    input  logic                pop,
    output logic [SAMPLE_W-1:0] head_left,
    output logic [SAMPLE_W-1:0] head_right,
    output logic [CNT_W-1:0]    count,
    output logic                full,
    output logic                empty
);

    logic [2*SAMPLE_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]      wr_ptr;
    logic [PTR_W-1:0]      rd_ptr;
    logic                  do_push;
    logic                  do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign {head_left, head_right} = store[rd_ptr];

    // Entry storage: written only on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) store[wr_ptr] <= {push_left, push_right};
    end

    // Pointer and count upkeep; flush returns to the empty state.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R3
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> $stable(count)); // R4
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0)); // R10

endmodule

// File: rtl/stf_irq_ctrl.sv
// Interrupt control: sticky underflow flag and the two interrupt outputs.
// Assumes uf_event is already qualified by the channel enable.
module stf_irq_ctrl #(
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic [CNT_W-1:0] count,
    input  logic             lvl_sel,
    input  logic             uf_irq_en,
    input  logic             uf_event,
    input  logic             uf_clear,
    output logic             fill_irq,
    output logic             uf_flag,
    output logic             uf_irq
);
    import stf_pkg::*;

    stf_lvl_e lvl;
    assign lvl = stf_lvl_e'(lvl_sel);

    // Fill-level compare against the selected threshold.
    always_comb begin
        if (!chan_en)              fill_irq = 1'b0;
        else if (lvl == LVL_EMPTY) fill_irq = (count == '0);
        else                       fill_irq = (count <= CNT_W'(DEPTH / 2));
    end

    // Sticky underflow flag; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        uf_flag <= 1'b0;
        else if (uf_event) uf_flag <= 1'b1;
        else if (uf_clear) uf_flag <= 1'b0;
    end

    assign uf_irq = uf_flag && uf_irq_en;

    AST_UF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        uf_event |=> uf_flag); // R8
    AST_UF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_flag && !uf_clear) |=> uf_flag); // R8

endmodule

// File: rtl/stereo_tx_fifo.sv
// Stereo transmit FIFO top: holds the left word, commits pairs on the
// right write, feeds the serializer with registered samples (zeros on
// underflow) and flushes everything while the channel is disabled.
// Assumes single-cycle strobes from the host and the serializer.
module stereo_tx_fifo #(
    parameter int SAMPLE_W = 16,
    parameter int DEPTH    = 8,
    localparam int CNT_W   = $clog2(DEPTH) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                chan_en,
    input  logic                wr_left,
    input  logic                wr_right,
    input  logic [SAMPLE_W-1:0] wr_data,
    input  logic                lvl_sel,
    input  logic                uf_irq_en,
    input  logic                uf_clear,
    input  logic                rd_req,
    output logic [SAMPLE_W-1:0] sample_left,
    output logic [SAMPLE_W-1:0] sample_right,
    output logic                full,
    output logic                fill_irq,
    output logic                uf_flag,
    output logic                uf_irq
);

    logic [SAMPLE_W-1:0] held_left;
    logic [SAMPLE_W-1:0] head_left;
    logic [SAMPLE_W-1:0] head_right;
    logic [CNT_W-1:0]    count;
    logic                buf_full;
    logic                buf_empty;
    logic                uf_event;
    logic                pop_req;

    assign pop_req  = chan_en && rd_req;
    assign uf_event = pop_req && buf_empty;
    assign full     = chan_en && buf_full;

    // Left holding register; a newer left write replaces an older one.
    always_ff @(posedge clk) begin
        if (!rst_n || !chan_en) held_left <= '0;
        else if (wr_left)       held_left <= wr_data;
    end

    // Serializer-facing sample registers, zero pair on underflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_left  <= '0;
            sample_right <= '0;
        end else if (pop_req) begin
            sample_left  <= buf_empty ? '0 : head_left;
            sample_right <= buf_empty ? '0 : head_right;
        end
    end

    stf_pair_buffer #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (!chan_en),
        .push       (chan_en && wr_right),
        .push_left  (held_left),
        .push_right (wr_data),
        .pop        (pop_req),
        .head_left  (head_left),
        .head_right (head_right),
        .count      (count),
        .full       (buf_full),
        .empty      (buf_empty)
    );

    stf_irq_ctrl #(.DEPTH(DEPTH)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_en   (chan_en),
        .count     (count),
        .lvl_sel   (lvl_sel),
        .uf_irq_en (uf_irq_en),
        .uf_event  (uf_event),
        .uf_clear  (uf_clear),
        .fill_irq  (fill_irq),
        .uf_flag   (uf_flag),
        .uf_irq    (uf_irq)
    );

    AST_UF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        uf_event |=> (sample_left == '0 && sample_right == '0)); // R8
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |-> (!full && !fill_irq)); // R10

endmodule

// File: tb/stereo_tx_fifo_test.sv
module stereo_tx_fifo_test;
    localparam int W = 16;
    localparam int D = 8;

    logic         clk = 1'b0;
    logic         rst_n, chan_en, wr_left, wr_right, lvl_sel, uf_irq_en, uf_clear, rd_req;
    logic [W-1:0] wr_data;
    logic [W-1:0] sample_left, sample_right;
    logic         full, fill_irq, uf_flag, uf_irq;
    int           n_checks = 0;
    int           n_fail   = 0;

    always #5 clk = ~clk;

    stereo_tx_fifo #(.SAMPLE_W(W), .DEPTH(D)) uut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .wr_left(wr_left),
        .wr_right(wr_right), .wr_data(wr_data), .lvl_sel(lvl_sel),
        .uf_irq_en(uf_irq_en), .uf_clear(uf_clear), .rd_req(rd_req),
        .sample_left(sample_left), .sample_right(sample_right), .full(full),
        .fill_irq(fill_irq), .uf_flag(uf_flag), .uf_irq(uf_irq)
    );

    function automatic logic [W-1:0] lval(int k); return W'(16'h1000 + k * 3); endfunction
    function automatic logic [W-1:0] rval(int k); return W'(16'hA000 ^ k); endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Advance one edge; inputs change 1 ns after the edge.
    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic write_pair(logic [W-1:0] l, logic [W-1:0] r);
        wr_left = 1'b1; wr_data = l; tick(); wr_left = 1'b0;
        wr_right = 1'b1; wr_data = r; tick(); wr_right = 1'b0;
    endtask

    task automatic read_pair();
        rd_req = 1'b1; tick(); rd_req = 1'b0;
    endtask

    initial begin
        #200000;
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 0; chan_en = 1; wr_left = 0; wr_right = 0; wr_data = '0;
        lvl_sel = 0; uf_irq_en = 1; uf_clear = 0; rd_req = 0;
        tick(); tick(); rst_n = 1; tick();

        // R1: reset state
        check(full == 0, "R1 full", int'(full), 0);
        check(sample_left == 0 && sample_right == 0, "R1 samples", int'(sample_left), 0);
        check(uf_flag == 0 && uf_irq == 0, "R1 uf", int'(uf_flag), 0);

        // R3 R6 R7: sweep fill level 0..D
        for (int k = 0; k <= D; k++) begin
            if (k > 0) write_pair(lval(k - 1), rval(k - 1));
            check(full == (k == D), "R3 full at level", int'(full), int'(k == D));
            lvl_sel = 0; #1;
            check(fill_irq == (k <= D / 2), "R6 half threshold", int'(fill_irq), int'(k <= D / 2));
            lvl_sel = 1; #1;
            check(fill_irq == (k == 0), "R7 empty threshold", int'(fill_irq), int'(k == 0));
        end
        lvl_sel = 0;

        // R4: write while full is dropped
        write_pair(16'hDEAD, 16'hBEEF);
        check(full == 1, "R4 still full", int'(full), 1);

        // R2: drain in order
        for (int k = 0; k < D; k++) begin
            read_pair();
            check(sample_left == lval(k), "R2 left order", int'(sample_left), int'(lval(k)));
            check(sample_right == rval(k), "R2 right order", int'(sample_right), int'(rval(k)));
        end
        check(uf_flag == 0, "R4 no extra entry", int'(uf_flag), 0);

        // R8: underflow yields zeros and sticky flag
        uf_irq_en = 0;
        read_pair();
        check(sample_left == 0 && sample_right == 0, "R8 zero pair", int'(sample_right), 0);
        check(uf_flag == 1, "R8 flag set", int'(uf_flag), 1);
        check(uf_irq == 0, "R9 masked", int'(uf_irq), 0);
        uf_irq_en = 1; #1;
        check(uf_irq == 1, "R9 enabled", int'(uf_irq), 1);
        tick(); tick();
        check(uf_flag == 1, "R8 sticky", int'(uf_flag), 1);
        uf_clear = 1; tick(); uf_clear = 0;
        check(uf_flag == 0 && uf_irq == 0, "R8 cleared", int'(uf_flag), 0);
        // R8: set wins over clear
        uf_clear = 1; rd_req = 1; tick(); uf_clear = 0; rd_req = 0;
        check(uf_flag == 1, "R8 set wins", int'(uf_flag), 1);
        uf_clear = 1; tick(); uf_clear = 0;

        // R5: second left write replaces the first
        wr_left = 1; wr_data = 16'h1111; tick();
        wr_data = 16'h2222; tick(); wr_left = 0;
        wr_right = 1; wr_data = 16'h3333; tick(); wr_right = 0;
        read_pair();
        check(sample_left == 16'h2222, "R5 latest left", int'(sample_left), 16'h2222);
        check(sample_right == 16'h3333, "R5 right", int'(sample_right), 16'h3333);

        // R10: disable flushes and ignores traffic
        for (int k = 0; k < 5; k++) write_pair(lval(k), rval(k));
        chan_en = 0; tick();
        check(full == 0 && fill_irq == 0, "R10 quiet while off", int'(fill_irq), 0);
        write_pair(16'h7777, 16'h8888);
        read_pair();
        check(sample_left == 16'h3333 || sample_left == 16'h2222, "R10 read ignored",
              int'(sample_left), 16'h2222);
        check(uf_flag == 0, "R10 no underflow while off", int'(uf_flag), 0);
        chan_en = 1; lvl_sel = 1; #1;
        check(fill_irq == 1, "R10 empty after re-enable", int'(fill_irq), 1);
        read_pair();
        check(sample_left == 0 && uf_flag == 1, "R10 flushed entries gone", int'(sample_left), 0);
        uf_clear = 1; tick(); uf_clear = 0;
        // Left holding was cleared: right-only write commits zero left.
        wr_right = 1; wr_data = 16'h4444; tick(); wr_right = 0;
        read_pair();
        check(sample_left == 0 && sample_right == 16'h4444, "R10 held left cleared",
              int'(sample_left), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule